// File: doc/BRIEF.md
# Timer Compare Channel Bank

This block holds a set of compare channels that watch a free-running time counter and its wrap pulse. Each channel keeps a programmed compare value. When the counter reaches or steps over that value, the channel sets a sticky event flag and, depending on a 4-bit mode field, either inverts its output pin or drives a high pulse of fixed length. The channel can also request an interrupt and a DMA transfer while its flag is set.

Each channel has two compare slots: an active slot and a queued slot. On every match the queued value moves into the active slot on its own. Software can therefore keep one value waiting behind the active one and top up the queue after each event. This gives a steady pulse train, such as one pulse per second, with no gaps between events.

Software reaches the channels through a small word-addressed register port. Reads are combinational. Writes take effect at the clock edge.

Top module: `tcmp_bank`

## Requirements
- R1: After a synchronous reset, every control register, flag, compare slot, pin, DMA request and the interrupt read as zero.
- R2: Register addresses:
  - Channel n's control register sits at byte address 0x608 + 8n.
  - Channel n's compare register sits at 0x60C + 8n.
  - Control bit layout: bit 7 is the event flag, bit 6 the interrupt enable, bits 5:2 the mode and bit 0 the DMA enable.
  - A read of the control register returns the written enables and mode together with the current flag.
- R3: The event flag is write-one-to-clear through control bit 7. A control write with bit 7 low leaves the flag as it was. A match in the same cycle as a clear wins.
- R4: Arming the compare slots:
  - While a channel is disarmed, the first compare write loads the active slot and arms it.
  - Each later compare write fills the queued slot.
  - A read of the compare register returns the active slot.
- R5: Match detection:
  - A match fires when the active value v satisfies prev < v <= cur, where prev is the counter one clock earlier and cur is the present counter.
  - In a cycle with the wrap pulse high, the test is v > prev or v <= cur.
  - A channel with mode zero or with no armed value never matches.
- R6: Slot promotion:
  - On a match, a queued value moves into the active slot and the queue becomes empty.
  - With an empty queue, the channel disarms and keeps its last active value for readback.
- R7: In mode 0x5, each match inverts the channel pin at the match clock edge.
- R8: Pulse and other modes:
  - In mode 0xF, each match drives the pin high for PULSE_LEN clocks, starting at the match clock edge.
  - Any other nonzero mode sets the flag and keeps the pin low.
- R9: The interrupt output is the OR over channels of flag AND interrupt enable. Each DMA request output is the channel flag AND its DMA enable.
- R10: A control write with mode zero disables the channel. It drives the pin low, empties both compare slots and leaves the flag unless bit 7 is also written.
- R11: Compare values are stored modulo 2^CNT_W; written bits at CNT_W and above are dropped.
- R12: A read at byte address 0x604 returns the channel flags in bits NCH-1:0, with channel n in bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Current time counter value |
| wrap_i | input | 1 | High in the cycle the counter has wrapped past its top |
| reg_addr | input | ADDR_W | Register byte address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| pin_o | output | NCH | Per-channel compare output pins |
| flag_o | output | NCH | Per-channel sticky event flags |
| dma_req_o | output | NCH | Per-channel DMA requests |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the bank with two channels, the full 31-bit counter and a 4-clock pulse. Two channels are enough to show the per-channel address stride, the per-bit status word and the interrupt OR. They also let one channel run while the other sits idle or disabled. The 31-bit counter lets compare values close to the top of the range be reached in one counter step, so the wrap-crossing match and the dropping of bit 31 can both be exercised. The short pulse keeps the whole high-then-low pulse shape inside a few sampled cycles.

// File: rtl/tcmp_pkg.sv
`timescale 1ns/1ps
package tcmp_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
    localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;

    // control byte, most significant field first
    typedef struct packed {
        logic              flag;
        logic              irq_en;
        logic [MODE_W-1:0] mode;
        logic              rsvd;
        logic              dma_en;
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int FLAG_BIT  = 7;

    // true when target lies in the half-open step (prev, cur],
    // taking a counter wrap inside the step into account
    function automatic logic crossed(input logic [31:0] prev,
                                     input logic [31:0] cur,
                                     input logic [31:0] tgt,
                                     input logic        wrapped);
        if (wrapped)
            return (tgt > prev) || (tgt <= cur);
        else
            return (tgt > prev) && (tgt <= cur);
    endfunction

endpackage

// File: rtl/tcmp_slot.sv
`timescale 1ns/1ps
module tcmp_slot #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disarm,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             enabled,
    input  logic [CNT_W-1:0] prev,
    input  logic [CNT_W-1:0] cur,
    input  logic             wrap,
    output logic             hit,
    output logic [CNT_W-1:0] act_o,
    output logic             armed_o
);
    import tcmp_pkg::*;

    logic [CNT_W-1:0] act_q, act_n;
    logic [CNT_W-1:0] que_q, que_n;
    logic             av_q, av_n;
    logic             qv_q, qv_n;

    assign hit = av_q && enabled &&
                 crossed(32'(prev), 32'(cur), 32'(act_q), wrap);

    always_comb begin
        act_n = act_q;
        que_n = que_q;
        av_n  = av_q;
        qv_n  = qv_q;
        if (hit) begin
            if (qv_q) begin
                act_n = que_q;
                qv_n  = 1'b0;
            end else begin
                av_n  = 1'b0;
            end
        end
        if (disarm) begin
            av_n = 1'b0;
            qv_n = 1'b0;
        end
        if (wr) begin
            if (!av_n) begin
                act_n = wdata;
                av_n  = 1'b1;
            end else begin
                que_n = wdata;
                qv_n  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            que_q <= '0;
            av_q  <= 1'b0;
            qv_q  <= 1'b0;
        end else begin
            act_q <= act_n;
            que_q <= que_n;
            av_q  <= av_n;
            qv_q  <= qv_n;
        end
    end

    assign act_o   = act_q;
    assign armed_o = av_q;

    // R6: queued value becomes active on a match, queue empties
    a_r6_promote: assert property (@(posedge clk) disable iff (rst)
        (hit && qv_q && !wr && !disarm) |=> (act_q == $past(que_q)) && !qv_q);

    // R6: match with empty queue leaves the slot disarmed
    a_r6_idle: assert property (@(posedge clk) disable iff (rst)
        (hit && !qv_q && !wr) |=> !av_q);

    // R4: first write into a disarmed slot arms it with that value
    a_r4_first_arm: assert property (@(posedge clk) disable iff (rst)
        (!av_q && wr && !disarm) |=> av_q && (act_q == $past(wdata)));

    // R5: no match without an enabled mode
    a_r5_need_mode: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> !hit);

endmodule

// File: rtl/tcmp_pin.sv
`timescale 1ns/1ps
module tcmp_pin #(
    parameter int PULSE_LEN = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [tcmp_pkg::MODE_W-1:0] mode,
    input  logic                      hit,
    input  logic                      cfg_wr,
    input  logic                      clr,
    output logic                      pin_o
);
    import tcmp_pkg::*;

    localparam int PW = $clog2(PULSE_LEN + 1);

    logic          tog_q;
    logic [PW-1:0] pls_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tog_q <= 1'b0;
            pls_q <= '0;
        end else if (hit) begin
            tog_q <= ~tog_q;
            pls_q <= PW'(PULSE_LEN);
        end else if (pls_q != '0) begin
            pls_q <= pls_q - 1'b1;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_TOGGLE: pin_o = tog_q;
            MODE_PULSE:  pin_o = (pls_q != '0);
            default:     pin_o = 1'b0;
        endcase
    end

    // R7: toggle mode flips the pin on each match
    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == MODE_TOGGLE && !cfg_wr) |=> (pin_o != $past(pin_o)));

    // R8: pulse mode drives the pin high after a match
    a_r8_pulse_high: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == MODE_PULSE && !cfg_wr) |=> pin_o);

    // R10: disabling pulls the pin low
    a_r10_off_low: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pin_o);

endmodule

// File: rtl/tcmp_chan.sv
`timescale 1ns/1ps
module tcmp_chan #(
    parameter int CNT_W     = 31,
    parameter int PULSE_LEN = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_ctrl,
    input  logic                        wr_cmp,
    input  logic [tcmp_pkg::CTRL_W-1:0] wbyte,
    input  logic [CNT_W-1:0]            wcmp,
    input  logic [CNT_W-1:0]            prev,
    input  logic [CNT_W-1:0]            cur,
    input  logic                        wrap,
    output logic [tcmp_pkg::CTRL_W-1:0] ctrl_rd,
    output logic [CNT_W-1:0]            cmp_rd,
    output logic                        flag_o,
    output logic                        irq_req,
    output logic                        dma_req,
    output logic                        pin_o
);
    import tcmp_pkg::*;

    ctrl_t ctrl_q, ctrl_n, wr_c;
    logic  hit;
    logic  disarm;
    logic  armed;

    assign wr_c   = ctrl_t'(wbyte);
    assign disarm = wr_ctrl && (wr_c.mode == MODE_OFF);

    always_comb begin
        ctrl_n = ctrl_q;
        if (wr_ctrl) begin
            ctrl_n.dma_en = wr_c.dma_en;
            ctrl_n.mode   = wr_c.mode;
            ctrl_n.irq_en = wr_c.irq_en;
            if (wr_c.flag)
                ctrl_n.flag = 1'b0;
        end
        if (hit)
            ctrl_n.flag = 1'b1;
        ctrl_n.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_n;
    end

    tcmp_slot #(.CNT_W(CNT_W)) slot_i (
        .clk     (clk),
        .rst     (rst),
        .disarm  (disarm),
        .wr      (wr_cmp),
        .wdata   (wcmp),
        .enabled (ctrl_q.mode != MODE_OFF),
        .prev    (prev),
        .cur     (cur),
        .wrap    (wrap),
        .hit     (hit),
        .act_o   (cmp_rd),
        .armed_o (armed)
    );

    tcmp_pin #(.PULSE_LEN(PULSE_LEN)) pin_i (
        .clk    (clk),
        .rst    (rst),
        .mode   (ctrl_q.mode),
        .hit    (hit),
        .cfg_wr (wr_ctrl),
        .clr    (disarm),
        .pin_o  (pin_o)
    );

    assign ctrl_rd = ctrl_q;
    assign flag_o  = ctrl_q.flag;
    assign irq_req = ctrl_q.flag && ctrl_q.irq_en;
    assign dma_req = ctrl_q.flag && ctrl_q.dma_en;

    // R3: flag holds unless cleared by a write of one
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !(wr_ctrl && wbyte[FLAG_BIT])) |=> ctrl_q.flag);

    // R5: a match always leaves the flag set
    a_r5_match_flag: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctrl_q.flag);

    // R10: disabling leaves nothing armed
    a_r10_disarmed: assert property (@(posedge clk) disable iff (rst)
        (disarm && !wr_cmp) |=> !armed);

endmodule

// File: rtl/tcmp_bank.sv
`timescale 1ns/1ps
module tcmp_bank #(
    parameter int NCH       = 4,
    parameter int CNT_W     = 31,
    parameter int PULSE_LEN = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int STAT_ADDR = 'h604,
    parameter int CH_BASE   = 'h608,
    parameter int CH_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wrap_i,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NCH-1:0]    pin_o,
    output logic [NCH-1:0]    flag_o,
    output logic [NCH-1:0]    dma_req_o,
    output logic              irq_o
);
    import tcmp_pkg::*;

    localparam int CMP_OFF = 4;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic [CNT_W-1:0]  prev_q;
    logic [NCH-1:0]    irq_vec;
    logic [CTRL_W-1:0] ctrl_rd [NCH];
    logic [CNT_W-1:0]  cmp_rd  [NCH];
    logic [NCH-1:0]    hit_ctrl;
    logic [NCH-1:0]    hit_cmp;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else
            prev_q <= cnt_i;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + n * CH_STRIDE);
        localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(CH_BASE + n * CH_STRIDE + CMP_OFF);

        assign hit_ctrl[n] = (reg_addr == A_CTRL);
        assign hit_cmp[n]  = (reg_addr == A_CMP);

        tcmp_chan #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .wr_ctrl (reg_wr && hit_ctrl[n]),
            .wr_cmp  (reg_wr && hit_cmp[n]),
            .wbyte   (reg_wdata[CTRL_W-1:0]),
            .wcmp    (reg_wdata[CNT_W-1:0]),
            .prev    (prev_q),
            .cur     (cnt_i),
            .wrap    (wrap_i),
            .ctrl_rd (ctrl_rd[n]),
            .cmp_rd  (cmp_rd[n]),
            .flag_o  (flag_o[n]),
            .irq_req (irq_vec[n]),
            .dma_req (dma_req_o[n]),
            .pin_o   (pin_o[n])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT)
            reg_rdata[NCH-1:0] = flag_o;
        for (int n = 0; n < NCH; n++) begin
            if (hit_ctrl[n])
                reg_rdata = DATA_W'(ctrl_rd[n]);
            if (hit_cmp[n])
                reg_rdata = DATA_W'(cmp_rd[n]);
        end
    end

    assign irq_o = |irq_vec;

    // R9: no interrupt while every flag is clear
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|flag_o) |-> !irq_o);

    // R9: DMA request only from a flagged channel
    a_r9_dma_flag: assert property (@(posedge clk) disable iff (rst)
        (dma_req_o & ~flag_o) == '0);

    // R1: reset leaves all outputs quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (pin_o == '0) && (flag_o == '0) && !irq_o);

endmodule

// File: tb/tcmp_bank_tb.sv
`timescale 1ns/1ps
module tcmp_bank_tb_top;

    localparam int NCH = 2;
    localparam int CW  = 31;
    localparam int PL  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cnt_i = '0;
    logic          wrap_i = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NCH-1:0] pin_o, flag_o, dma_req_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tcmp_bank #(.NCH(NCH), .CNT_W(CW), .PULSE_LEN(PL)) dut_i (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .wrap_i(wrap_i),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pin_o(pin_o), .flag_o(flag_o),
        .dma_req_o(dma_req_o), .irq_o(irq_o)
    );

    // counter walk for channel 0 in toggle mode, compares 100 then 200
    localparam int NV = 8;
    localparam logic [30:0] V_CNT [NV] = '{31'd30, 31'd60, 31'd90, 31'd120,
                                          31'd150, 31'd180, 31'd200, 31'd230};
    localparam logic V_PIN [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic V_FLG [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [30:0] c, input logic w);
        cnt_i  = c;
        wrap_i = w;
        @(negedge clk);
        wrap_i = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pins", 32'(pin_o), 0);
        chk("R1 flags", 32'(flag_o), 0);
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 dma", 32'(dma_req_o), 0);
        rd(12'h608, r); chk("R1 ctrl0", r, 0);
        rd(12'h614, r); chk("R1 cmp1", r, 0);

        // R4 arming and queueing
        wr(12'h60C, 100);
        wr(12'h60C, 200);
        rd(12'h60C, r); chk("R4 active after two writes", r, 100);
        wr(12'h608, 32'h54);
        rd(12'h608, r); chk("R2 ctrl readback", r, 32'h54);

        // R5 R6 R7 table walk
        for (int i = 0; i < NV; i++) begin
            tick(V_CNT[i], 1'b0);
            chk("R7 toggle pin", 32'(pin_o[0]), 32'(V_PIN[i]));
            chk("R5 flag after step", 32'(flag_o[0]), 32'(V_FLG[i]));
            chk("R9 irq follows flag", 32'(irq_o), 32'(V_FLG[i]));
        end
        rd(12'h60C, r); chk("R6 promoted value", r, 200);
        rd(12'h604, r); chk("R12 status ch0", r, 32'h1);

        // R3 flag clear
        wr(12'h608, 32'h54);
        chk("R3 flag kept on bit7 low", 32'(flag_o[0]), 1);
        wr(12'h608, 32'hD4);
        chk("R3 flag cleared", 32'(flag_o[0]), 0);
        chk("R9 irq low after clear", 32'(irq_o), 0);
        rd(12'h608, r); chk("R3 ctrl after clear", r, 32'h54);

        // R8 pulse on channel 1 near counter top
        wr(12'h614, 32'h7FFFFFF0);
        wr(12'h614, 5);
        wr(12'h610, 32'h3C);
        tick(31'h7FFFFFE0, 1'b0);
        chk("R5 no early match", 32'(pin_o[1]), 0);
        tick(31'h7FFFFFF8, 1'b0);
        chk("R8 pulse starts", 32'(pin_o[1]), 1);
        chk("R5 step-over match flag", 32'(flag_o[1]), 1);
        chk("R9 irq gated by enable", 32'(irq_o), 0);
        for (int k = 1; k < PL; k++) begin
            tick(31'h7FFFFFF8, 1'b0);
            chk("R8 pulse held", 32'(pin_o[1]), 1);
        end
        tick(31'h7FFFFFF8, 1'b0);
        chk("R8 pulse ended", 32'(pin_o[1]), 0);
        rd(12'h614, r); chk("R6 queued moved up", r, 5);
        rd(12'h604, r); chk("R12 status ch1", r, 32'h2);

        // R5 match across wrap
        tick(31'd6, 1'b1);
        chk("R5 wrap match pulse", 32'(pin_o[1]), 1);

        // R10 disable keeps flag, drops pin
        wr(12'h610, 0);
        chk("R10 pin low", 32'(pin_o[1]), 0);
        chk("R10 flag kept", 32'(flag_o[1]), 1);
        rd(12'h610, r); chk("R10 ctrl read", r, 32'h80);
        wr(12'h610, 32'h80);
        chk("R3 flag cleared ch1", 32'(flag_o[1]), 0);

        // R5 disabled channel ignores crossing
        wr(12'h614, 50);
        tick(31'd60, 1'b0);
        chk("R5 disabled no flag", 32'(flag_o[1]), 0);
        rd(12'h614, r); chk("R10 rearm after disable", r, 50);

        // R11 modulo
        wr(12'h610, 0);
        wr(12'h614, 32'h80000064);
        rd(12'h614, r); chk("R11 top bit dropped", r, 32'h64);

        // R9 DMA on channel 0 pulse mode
        wr(12'h608, 0);
        wr(12'h60C, 80);
        wr(12'h608, 32'h3D);
        tick(31'd90, 1'b0);
        chk("R9 dma request", 32'(dma_req_o), 32'h1);
        chk("R8 pulse ch0", 32'(pin_o[0]), 1);
        chk("R9 irq off", 32'(irq_o), 0);
        wr(12'h608, 32'h7D);
        chk("R9 irq on enable", 32'(irq_o), 1);

        // R8 other nonzero mode: flag only
        wr(12'h610, 32'h08);
        tick(31'd112, 1'b0);
        chk("R8 other mode flag", 32'(flag_o[1]), 1);
        chk("R8 other mode pin low", 32'(pin_o[1]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule